// File: doc/BRIEF.md
# GPIO Port Direction Override Controller

This block controls an 8-pin general-purpose I/O port. Software owns three registers through a small synchronous bus: an output latch, a direction register and a drive-strength register. A fourth address returns the pin levels seen by the block after a two-flop synchroniser. Pin levels are never sampled straight from the pads.

Three peripheral flags can take a pin away from software. A segment-display enable turns both pad buffers off. A PWM channel enable forces the pin to drive. On the shutdown pin only, a PWM shutdown flag forces the pin to receive. The fixed priority is: segment display, then shutdown, then PWM channel, then the software direction bit. An override never modifies a stored register bit. When a PWM channel owns a pin, the pad takes the channel's waveform instead of the latch.

The block drives per-pin output-enable, input-enable, reduced-drive and pad data signals.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the latch, direction and drive registers read 0, every pin has input enabled and output disabled, and no reduced-drive control is set.
- R2: With no override on a pin, direction bit 1 gives output enable 1 and input enable 0, and direction bit 0 gives output enable 0 and input enable 1. The two enables are never both 1.
- R3: A pin whose segment-display enable is 1 has both output enable and input enable at 0, whatever its other flags and register bits are.
- R4: A pin whose PWM channel enable is 1 is an output when no higher-priority override applies, whatever its direction bit is. Its pad data is the PWM waveform bit; otherwise pad data is the latch bit.
- R5: On pin 7 only, the shutdown flag, when the segment display is off, forces input (output enable 0, input enable 1), even when the PWM channel is enabled. The flag has no effect on pins 0 to 6.
- R6: The direction register keeps its software-written value while overrides are active, and reading it returns that value, not the effective direction.
- R7: The pin-level register (address 1) shows a pad level change only after two rising clock edges.
- R8: Reading address 0 returns the latch bit for pins whose output enable is 1, and the synchronised pin level for all other pins. Reading address 1 always returns the synchronised pin level.
- R9: A pin's reduced-drive output is 1 exactly when its output enable is 1 and its drive-register bit is 1.
- R10: A write with wr_en high updates the addressed register at the next rising edge, and not before. Writes to address 1 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 pin level, 2 direction, 3 drive |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Pad input levels |
| seg_en | input | 8 | Per-pin segment-display enable |
| pwm_en | input | 8 | Per-pin PWM channel enable |
| pwm_wave | input | 8 | Per-pin PWM waveform |
| pwm_shut | input | 1 | PWM shutdown flag for pin 7 |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enable |
| pad_ie | output | 8 | Pad input enable |
| pad_rdrv | output | 8 | Reduced-drive select |

## Verification
The synchroniser lag assertion assumes that the pad inputs are sampled at clean clock edges. It only starts comparing once the two stages have filled after reset. The bench meets this by changing pins only on falling edges.

The override assertions assume the flags are level signals held stable between edges. The bench changes them only on falling edges and samples one time unit later. Register-hold properties assume the strobe is low except during a deliberate write, and the bench drops it on the falling edge after each write.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_DRIVE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_IN  = 2'd1,
        MODE_OUT = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o
);
    localparam int CW = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
        logic [CW-1:0]            fill;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.stage[k] = st_q.stage[k-1];
        end
        if (st_q.fill != CW'(STAGES)) begin
            st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.stage[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lag_chk
            // R7: output trails the pad by exactly two edges once filled
            p_sync_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.fill == CW'(STAGES)) |-> (level_o == $past(pin_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      out_mask_i,
    input  logic [W-1:0]      level_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      latch_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      drive_o
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
        logic [W-1:0] drive;
    } regs_t;

    regs_t    rg_d, rg_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        rg_d = rg_q;
        if (wr_i) begin
            unique case (sel)
                SEL_LATCH: rg_d.latch = wdata_i;
                SEL_DIR:   rg_d.dir   = wdata_i;
                SEL_DRIVE: rg_d.drive = wdata_i;
                default:   rg_d       = rg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (sel)
            SEL_LATCH: rdata_o = (rg_q.latch & out_mask_i) | (level_i & ~out_mask_i);
            SEL_LEVEL: rdata_o = level_i;
            SEL_DIR:   rdata_o = rg_q.dir;
            default:   rdata_o = rg_q.drive;
        endcase
    end

    assign latch_o = rg_q.latch;
    assign dir_o   = rg_q.dir;
    assign drive_o = rg_q.drive;

    // R6: direction bits move only on a bus write to the direction address
    p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel == SEL_DIR) |=> $stable(rg_q.dir));
    // R10: a write lands on the following edge
    p_wr_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_DIR) |=> (rg_q.dir == $past(wdata_i)));
    // R10: the pin-level address is read-only
    p_level_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_LEVEL) |=> $stable(rg_q));
endmodule

// File: rtl/gpio_ovr_resolve.sv
module gpio_ovr_resolve
    import gpio_ovr_pkg::*;
#(
    parameter int W        = 8,
    parameter int SHUT_PIN = 7
) (
    input  logic [W-1:0] seg_i,
    input  logic [W-1:0] pwm_i,
    input  logic [W-1:0] wave_i,
    input  logic         shut_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] drive_i,
    input  logic [W-1:0] latch_i,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] ie_o,
    output logic [W-1:0] rdrv_o,
    output logic [W-1:0] pad_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            localparam bit HAS_SHUT = (i == SHUT_PIN);
            pin_mode_e mode;
            logic      pwm_owns;

            always_comb begin
                pwm_owns = 1'b0;
                if (seg_i[i]) begin
                    mode = MODE_OFF;
                end else if (HAS_SHUT && shut_i) begin
                    mode = MODE_IN;
                end else if (pwm_i[i]) begin
                    mode     = MODE_OUT;
                    pwm_owns = 1'b1;
                end else if (dir_i[i]) begin
                    mode = MODE_OUT;
                end else begin
                    mode = MODE_IN;
                end
            end

            assign oe_o[i]   = (mode == MODE_OUT);
            assign ie_o[i]   = (mode == MODE_IN);
            assign rdrv_o[i] = (mode == MODE_OUT) && drive_i[i];
            assign pad_o[i]  = pwm_owns ? wave_i[i] : latch_i[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int W        = 8,
    parameter int SHUT_PIN = 7,
    parameter int STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    input  logic [W-1:0]      seg_en,
    input  logic [W-1:0]      pwm_en,
    input  logic [W-1:0]      pwm_wave,
    input  logic              pwm_shut,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_ie,
    output logic [W-1:0]      pad_rdrv
);
    localparam logic [W-1:0] SHUT_MASK = W'(1) << SHUT_PIN;

    logic [W-1:0] level, latch, dir, drive;

    gpio_ovr_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .level_o(level)
    );

    gpio_ovr_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .out_mask_i(pad_oe), .level_i(level),
        .rdata_o(bus_rdata), .latch_o(latch), .dir_o(dir), .drive_o(drive)
    );

    gpio_ovr_resolve #(.W(W), .SHUT_PIN(SHUT_PIN)) u_res (
        .seg_i(seg_en), .pwm_i(pwm_en), .wave_i(pwm_wave), .shut_i(pwm_shut),
        .dir_i(dir), .drive_i(drive), .latch_i(latch),
        .oe_o(pad_oe), .ie_o(pad_ie), .rdrv_o(pad_rdrv), .pad_o(pad_out)
    );

    // R2: a pad never has both buffers on
    p_enables_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_ie) == '0);
    // R3: segment display switches both buffers off
    p_seg_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en & (pad_oe | pad_ie)) == '0);
    // R4: an enabled PWM channel drives unless a stronger override applies
    p_pwm_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en & ~seg_en & ~(pwm_shut ? SHUT_MASK : '0) & ~pad_oe) == '0);
    // R5: shutdown forces the shutdown pin to receive
    p_shut_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_shut && !seg_en[SHUT_PIN]) |-> (pad_ie[SHUT_PIN] && !pad_oe[SHUT_PIN]));
    // R9: reduced drive only on driving pins
    p_rdrv_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_rdrv & ~pad_oe) == '0);
endmodule

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00, seg_en = 8'h00, pwm_en = 8'h00, pwm_wave = 8'h00;
    logic       pwm_shut = 1'b0;
    logic [7:0] pad_out, pad_oe, pad_ie, pad_rdrv;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ovr_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .seg_en(seg_en), .pwm_en(pwm_en), .pwm_wave(pwm_wave), .pwm_shut(pwm_shut),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_rdrv(pad_rdrv)
    );

    typedef struct packed {
        logic [7:0] seg;
        logic [7:0] pwm;
        logic       shut;
        logic [7:0] dir;
        logic [7:0] drv;
        logic [7:0] e_oe;
        logic [7:0] e_ie;
        logic [7:0] e_rdrv;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{8'h00, 8'h00, 1'b0, 8'hF0, 8'hFF, 8'hF0, 8'h0F, 8'hF0},
        '{8'h0F, 8'h00, 1'b0, 8'hFF, 8'hFF, 8'hF0, 8'h00, 8'hF0},
        '{8'h00, 8'h3C, 1'b0, 8'h00, 8'h0F, 8'h3C, 8'hC3, 8'h0C},
        '{8'h00, 8'h80, 1'b1, 8'h80, 8'h80, 8'h00, 8'hFF, 8'h00},
        '{8'h80, 8'h80, 1'b1, 8'hFF, 8'h00, 8'h7F, 8'h00, 8'h00},
        '{8'h00, 8'h01, 1'b1, 8'h00, 8'hFF, 8'h01, 8'hFE, 8'h01},
        '{8'hAA, 8'h55, 1'b0, 8'h00, 8'hFF, 8'h55, 8'h00, 8'h55},
        '{8'h00, 8'h00, 1'b1, 8'h7F, 8'hAA, 8'h7F, 8'h80, 8'h2A}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); chk("R1 latch read", rd, 8'h00);
        bus_read(2'd2, rd); chk("R1 dir read", rd, 8'h00);
        bus_read(2'd3, rd); chk("R1 drive read", rd, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 ie", pad_ie, 8'hFF);
        chk("R1 rdrv", pad_rdrv, 8'h00);

        // table of override scenarios: R2 R3 R4 R5 R6 R9
        for (int v = 0; v < 8; v++) begin
            bus_write(2'd2, TBL[v].dir);
            bus_write(2'd3, TBL[v].drv);
            seg_en = TBL[v].seg; pwm_en = TBL[v].pwm; pwm_shut = TBL[v].shut;
            #1;
            chk("R2/R3/R4/R5 oe", pad_oe, TBL[v].e_oe);
            chk("R2/R3/R5 ie", pad_ie, TBL[v].e_ie);
            chk("R9 rdrv", pad_rdrv, TBL[v].e_rdrv);
            bus_read(2'd2, rd);
            chk("R6 dir readback under override", rd, TBL[v].dir);
        end
        seg_en = 8'h00; pwm_en = 8'h00; pwm_shut = 1'b0;

        // R8 data read mux and R4 pad data select
        pin_in = 8'h3C;
        bus_write(2'd0, 8'hA5);
        bus_write(2'd2, 8'h0F);
        repeat (3) @(negedge clk);
        bus_read(2'd0, rd); chk("R8 latch/level mux", rd, 8'h35);
        bus_read(2'd1, rd); chk("R8 level read", rd, 8'h3C);
        chk("R4 pad data from latch", pad_out, 8'hA5);
        pwm_en = 8'h01; pwm_wave = 8'h00;
        #1 chk("R4 pad data from waveform", pad_out, 8'hA4);
        pwm_en = 8'h00;

        // R7 two-edge synchroniser lag
        @(negedge clk);
        pin_in = 8'h81; bus_addr = 2'd1;
        #1 chk("R7 level before edges", bus_rdata, 8'h3C);
        @(negedge clk);
        #1 chk("R7 level after one edge", bus_rdata, 8'h3C);
        @(negedge clk);
        #1 chk("R7 level after two edges", bus_rdata, 8'h81);

        // R10 write takes effect at next edge, not before
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'hFF; bus_wr = 1'b1;
        #1 chk("R10 oe before edge", pad_oe, 8'h0F);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 chk("R10 oe after edge", pad_oe, 8'hFF);

        // R10 writes to the level address are ignored
        bus_write(2'd1, 8'h00);
        bus_read(2'd2, rd); chk("R10 dir after level write", rd, 8'hFF);
        bus_read(2'd3, rd); chk("R10 drive after level write", rd, 8'hAA);
        bus_read(2'd0, rd); chk("R10 latch after level write", rd, 8'hA5);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule